// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns a single burst request into the series of column addresses that a memory read or write burst visits, one address per clock beat. A request carries a starting column, a burst length code and an ordering select. From the cycle after the request is taken, the block presents one column address per cycle and flags the final beat. The low column bits move only inside an aligned group as large as the burst. The column bits above that group are passed through unchanged.

Two orderings are available. In sequential order the offset inside the group counts upward and wraps back to the start of the same group. In interleaved order the offset on each beat is the starting offset XOR the beat number. While a burst is running, the block ignores any new request and holds its busy output high. Length codes other than the three legal ones start no burst.

Top module: `burst_col_seq`

## Requirements
- R1: A request (`start_i` high at a rising edge) with a legal length code, made while the block is idle, is taken. On the next cycle `valid_o` is high and `col_o` equals the requested column.
- R2: Length code 3'b001 gives 2 beats, 3'b010 gives 4 beats and 3'b011 gives 8 beats. `valid_o` stays high for exactly that many consecutive cycles.
- R3: The bits of `col_o` above the burst group (bit 1 and up for 2 beats, bit 2 and up for 4, bit 3 and up for 8) equal the requested column on every beat.
- R4: With `order_i` = 0 (sequential), the in-group offset on beat k is (start offset + k) modulo the length. Example: 8 beats from offset 5 give 5,6,7,0,1,2,3,4.
- R5: With `order_i` = 1 (interleaved), the in-group offset on beat k is the start offset XOR k. Example: 8 beats from offset 5 give 5,4,7,6,1,0,3,2, and 4 beats from offset 1 give 1,0,3,2.
- R6: A 2-beat burst gives the same order in both modes: 0,1 from offset 0 and 1,0 from offset 1.
- R7: A request made while a burst is in progress, including on its last beat, is ignored. The running burst continues unchanged and no second burst follows it.
- R8: A request with a reserved length code (3'b000 or 3'b100 to 3'b111) starts no burst. `valid_o` and `busy_o` stay low.
- R9: `last_o` is high only together with the final address of a burst. `busy_o` is high exactly on the cycles that carry a beat. After reset, `busy_o`, `valid_o` and `last_o` are low.
- R10: The column, length and order are sampled only when a request is taken. Changes to them during a burst have no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Burst request |
| col_i | input | COL_W | Starting column address |
| blen_i | input | 3 | Burst length code (001=2, 010=4, 011=8) |
| order_i | input | 1 | Ordering select: 0 sequential, 1 interleaved |
| busy_o | output | 1 | A burst is in progress |
| valid_o | output | 1 | `col_o` carries a beat address this cycle |
| col_o | output | COL_W | Column address of the current beat |
| last_o | output | 1 | Current beat is the final one of the burst |

## Verification
Every burst is compared beat by beat against a queue-based model. An 8-beat burst is run from the same odd offset in both orders, which separates a correct wrap from an XOR order. A 4-beat burst and 2-beat bursts from both offsets confirm that the group width follows the length code and that the two orders agree at length two. Starting columns with set upper bits catch carries leaking out of the group. A request held high across a whole burst, and inputs changed in mid-burst, show that nothing is resampled too early. Every reserved code is tried and must leave the outputs idle.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    // Widest burst is 2**MAX_LG beats
    localparam int MAX_LG = 3;
    localparam int BEAT_W = MAX_LG;
    localparam int LG_W   = 2;

    typedef enum logic [2:0] {
        BL_RSV  = 3'b000,
        BL_TWO  = 3'b001,
        BL_FOUR = 3'b010,
        BL_EIGHT = 3'b011
    } blen_e;

    typedef enum logic {
        ORD_SEQ   = 1'b0,
        ORD_INTLV = 1'b1
    } order_e;

    typedef struct packed {
        logic            legal;
        logic [LG_W-1:0] lg;
    } blen_dec_t;

    typedef struct packed {
        logic              active;
        logic [BEAT_W-1:0] beat;
        logic [BEAT_W-1:0] mask;
        order_e            order;
    } burst_ctx_t;

    function automatic blen_dec_t decode_blen(input logic [2:0] code);
        blen_dec_t d;
        d.legal = 1'b1;
        case (code)
            BL_TWO:   d.lg = 2'd1;
            BL_FOUR:  d.lg = 2'd2;
            BL_EIGHT: d.lg = 2'd3;
            default: begin
                d.legal = 1'b0;
                d.lg    = 2'd0;
            end
        endcase
        return d;
    endfunction

    function automatic logic [BEAT_W-1:0] lg_to_mask(input logic [LG_W-1:0] lg);
        logic [BEAT_W-1:0] m;
        for (int i = 0; i < BEAT_W; i++) begin
            m[i] = (i < int'(lg));
        end
        return m;
    endfunction

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
    import burst_seq_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic [2:0]        blen_i,
    input  logic              order_i,
    output logic              active_o,
    output logic [BEAT_W-1:0] beat_o,
    output logic [BEAT_W-1:0] mask_o,
    output order_e            order_o,
    output logic [COL_W-1:0]  base_o,
    output logic              last_o
);

    burst_ctx_t       ctx_q;
    logic [COL_W-1:0] base_q;
    blen_dec_t        dec;
    logic             accept;
    logic             final_beat;

    assign dec        = decode_blen(blen_i);
    assign accept     = start_i && !ctx_q.active && dec.legal;
    assign final_beat = ctx_q.active && (ctx_q.beat == ctx_q.mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q.active <= 1'b0;
            ctx_q.beat   <= '0;
            ctx_q.mask   <= '0;
            ctx_q.order  <= ORD_SEQ;
            base_q       <= '0;
        end else if (accept) begin
            ctx_q.active <= 1'b1;
            ctx_q.beat   <= '0;
            ctx_q.mask   <= lg_to_mask(dec.lg);
            ctx_q.order  <= order_e'(order_i);
            base_q       <= col_i;
        end else if (ctx_q.active) begin
            if (final_beat) begin
                ctx_q.active <= 1'b0;
                ctx_q.beat   <= '0;
            end else begin
                ctx_q.beat <= ctx_q.beat + 1'b1;
            end
        end
    end

    assign active_o = ctx_q.active;
    assign beat_o   = ctx_q.beat;
    assign mask_o   = ctx_q.mask;
    assign order_o  = ctx_q.order;
    assign base_o   = base_q;
    assign last_o   = final_beat;

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_seq_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0]  base_i,
    input  logic [BEAT_W-1:0] beat_i,
    input  logic [BEAT_W-1:0] mask_i,
    input  order_e            order_i,
    output logic [COL_W-1:0]  col_o
);

    logic [BEAT_W-1:0] start_off;
    logic [BEAT_W-1:0] seq_off;
    logic [BEAT_W-1:0] xor_off;
    logic [BEAT_W-1:0] sel_off;

    assign start_off = base_i[BEAT_W-1:0];
    // Carries out of the group are dropped by the per-bit mask below
    assign seq_off   = start_off + beat_i;
    assign xor_off   = start_off ^ beat_i;
    assign sel_off   = (order_i == ORD_INTLV) ? xor_off : seq_off;

    for (genvar g = 0; g < BEAT_W; g++) begin : g_low
        assign col_o[g] = mask_i[g] ? sel_off[g] : base_i[g];
    end

    assign col_o[COL_W-1:BEAT_W] = base_i[COL_W-1:BEAT_W];

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import burst_seq_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [COL_W-1:0] col_i,
    input  logic [2:0]       blen_i,
    input  logic             order_i,
    output logic             busy_o,
    output logic             valid_o,
    output logic [COL_W-1:0] col_o,
    output logic             last_o
);

    logic              active;
    logic [BEAT_W-1:0] beat;
    logic [BEAT_W-1:0] mask;
    order_e            order;
    logic [COL_W-1:0]  base;
    logic              final_beat;

    burst_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .col_i    (col_i),
        .blen_i   (blen_i),
        .order_i  (order_i),
        .active_o (active),
        .beat_o   (beat),
        .mask_o   (mask),
        .order_o  (order),
        .base_o   (base),
        .last_o   (final_beat)
    );

    burst_addr_gen #(.COL_W(COL_W)) u_addr (
        .base_i  (base),
        .beat_i  (beat),
        .mask_i  (mask),
        .order_i (order),
        .col_o   (col_o)
    );

    assign busy_o  = active;
    assign valid_o = active;
    assign last_o  = final_beat;

endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic [COL_W-1:0] col_i,
    input logic [2:0]       blen_i,
    input logic             order_i,
    input logic             busy_o,
    input logic             valid_o,
    input logic [COL_W-1:0] col_o,
    input logic             last_o
);

    logic legal_code;
    assign legal_code = (blen_i == 3'b001) || (blen_i == 3'b010) || (blen_i == 3'b011);

    p_first_beat_r1: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && legal_code) |=> (valid_o && col_o == $past(col_i)));

    p_upper_fixed_r3: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !last_o) |=> (col_o[COL_W-1:3] == $past(col_o[COL_W-1:3])));

    p_busy_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !last_o) |=> busy_o);

    p_reserved_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && !legal_code) |=> !busy_o);

    p_last_valid_r9: assert property (@(posedge clk) disable iff (rst)
        last_o |-> valid_o);

    p_last_ends_r9: assert property (@(posedge clk) disable iff (rst)
        last_o |=> !busy_o);

endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (.*);

// File: tb/sim_burst_col_seq.sv
module sim_burst_col_seq;

    localparam int COL_W = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] col_i = '0;
    logic [2:0]       blen_i = 3'b000;
    logic             order_i = 1'b0;
    logic             busy_o;
    logic             valid_o;
    logic [COL_W-1:0] col_o;
    logic             last_o;

    int    compared = 0;
    int    mismatched = 0;
    bit    check_en = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R9";
    int    exp_q[$];

    always #10 clk = ~clk;

    burst_col_seq #(.COL_W(COL_W)) u0 (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .col_i   (col_i),
        .blen_i  (blen_i),
        .order_i (order_i),
        .busy_o  (busy_o),
        .valid_o (valid_o),
        .col_o   (col_o),
        .last_o  (last_o)
    );

    // Reference model: a queue of expected beat addresses
    task automatic push_burst(input int col, input int code, input bit intlv);
        int len;
        case (code)
            1: len = 2;
            2: len = 4;
            3: len = 8;
            default: len = 0;
        endcase
        for (int k = 0; k < len; k++) begin
            int s;
            int off;
            s   = col % len;
            off = intlv ? (s ^ k) : ((s + k) % len);
            exp_q.push_back((col / len) * len + off);
        end
    endtask

    always @(posedge clk) begin
        bit was_idle;
        if (rst) begin
            exp_q.delete();
        end else begin
            was_idle = (exp_q.size() == 0);
            if (!was_idle) void'(exp_q.pop_front());
            if (was_idle && start_i) push_burst(int'(col_i), int'(blen_i), order_i);
        end
    end

    always @(negedge clk) begin
        if (check_en && !done) begin
            bit exp_v;
            bit exp_l;
            int exp_c;
            exp_v = (exp_q.size() > 0);
            exp_l = (exp_q.size() == 1);
            exp_c = exp_v ? exp_q[0] : 0;
            compared++;
            if (valid_o !== exp_v || busy_o !== exp_v || last_o !== exp_l ||
                (exp_v && int'(col_o) != exp_c)) begin
                mismatched++;
                $display("FAIL %s: valid=%0b busy=%0b last=%0b col=%0h, expected valid=%0b busy=%0b last=%0b col=%0h",
                         cur_req, valid_o, busy_o, last_o, col_o, exp_v, exp_v, exp_l, exp_c);
            end
        end
    end

    task automatic request(input int col, input int code, input bit intlv, input int hold);
        @(negedge clk);
        start_i = 1'b1;
        col_i   = COL_W'(col);
        blen_i  = 3'(code);
        order_i = intlv;
        repeat (hold) @(negedge clk);
        start_i = 1'b0;
        repeat (11) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        compared++;
        if (busy_o !== 1'b0 || valid_o !== 1'b0 || last_o !== 1'b0) begin
            mismatched++;
            $display("FAIL R9: reset busy=%0b valid=%0b last=%0b, expected 0 0 0",
                     busy_o, valid_o, last_o);
        end
        rst = 1'b0;
        check_en = 1'b1;
        repeat (2) @(negedge clk);

        cur_req = "R4"; request(5, 3, 1'b0, 1);
        cur_req = "R5"; request(5, 3, 1'b1, 1);
        cur_req = "R2"; request(1, 2, 1'b0, 1);
        cur_req = "R5"; request(1, 2, 1'b1, 1);
        cur_req = "R6"; request(1, 1, 1'b0, 1);
        cur_req = "R6"; request(1, 1, 1'b1, 1);
        cur_req = "R6"; request(0, 1, 1'b1, 1);
        cur_req = "R3"; request(10'h3A5, 3, 1'b0, 1);
        cur_req = "R3"; request(10'h3A6, 2, 1'b1, 1);
        cur_req = "R3"; request(10'h2FF, 1, 1'b0, 1);
        // request held high across bursts: taken again only once idle
        cur_req = "R7"; request(10'h013, 3, 1'b0, 14);
        cur_req = "R1"; request(10'h101, 2, 1'b1, 7);
        cur_req = "R8";
        for (int c = 0; c < 8; c++) begin
            if (c == 0 || c >= 4) request(10'h155, c, 1'b0, 2);
        end
        // R10: change inputs while a burst runs
        cur_req = "R10";
        @(negedge clk);
        start_i = 1'b1; col_i = 10'h0C3; blen_i = 3'b011; order_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0; col_i = 10'h3FF; blen_i = 3'b001; order_i = 1'b1;
        repeat (12) @(negedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: run not finished, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule